// File: doc/BRIEF.md
# Differential Sum-of-Sinusoids Fading Generator

This block produces a stream of complex Rayleigh-style fading samples for one propagation path. Each path is the sum of `NSIN` sinusoids. Every sinusoid has its own phase and its own per-step phase increment, and the increment sets its Doppler frequency. A single datapath is shared in time across all sinusoid slots, one slot per clock. The in-phase part sums the cosines of the slot phases and the quadrature part sums the sines.

The core does not rebuild the sum on every sweep. Each sweep adds up, over all slots, the change in every sinusoid's value between the old phase and the advanced phase. A running accumulator then absorbs that total. The first sweep after start is a priming sweep: the previous value counts as zero and the phases do not move, so the accumulator begins from the direct sum at the loaded phases.

One low-rate sample is produced for every `NSIN`-cycle sweep. A linear interpolator raises the rate by `2**UPL` and emits one complex output with a one-cycle valid strobe every `NSIN/2**UPL` cycles. Software-side loading is a simple slot-addressed write of a phase and an increment while the generator is stopped.

Top module: `fade_sos_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: The waveform value for an `LA`-bit index x is computed as follows. Let H = 2**(LA-1) and t = x mod H. The magnitude is floor(AMP*4*t*(H-t)/H²). The value is negative when x ≥ H and positive otherwise. The index is the top `LA` bits of a slot phase. The sine uses that index directly. The cosine uses the index plus H/2, modulo 2**LA.
- R3: The first low-rate sample after `run` rises is the direct sum over all slots of cosine (I) and sine (Q), evaluated at the loaded phases.
- R4: Low-rate sample m (m ≥ 1) equals exactly the direct sum over slots evaluated at phase (p0 + m·inc) mod 2**PW. The differential accumulation introduces no error.
- R5: Output number j (0 ≤ j < 2**UPL) between low-rate samples y[m-1] and y[m] is y[m-1] + floor((y[m]-y[m-1])·j / 2**UPL). The outputs for that pair are emitted during the sweep that follows the one producing y[m].
- R6: `out_valid` is high for exactly one cycle every `NSIN/2**UPL` cycles. The first pulse follows the 2·NSIN+1-th rising clock edge after `run` was sampled high.
- R7: When `run` is low, no valid output appears from the next cycle onward. A later rise of `run` starts a new priming sweep.
- R8: `cfg_we` writes `cfg_phase` and `cfg_inc` into the slot addressed by `cfg_sel` only while `run` is low. Writes while `run` is high have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Generator enable; rising starts a priming sweep |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_sel | input | clog2(NSIN) | Slot addressed by a configuration write |
| cfg_phase | input | PW | Initial phase for the slot |
| cfg_inc | input | PW | Phase increment per low-rate sample for the slot |
| out_i | output | OW | In-phase output, signed |
| out_q | output | OW | Quadrature output, signed |
| out_valid | output | 1 | One-cycle strobe for each output sample |

## Verification
The bench builds the block with its defaults: 32 slots, 16-bit phases, an 8-bit table index, amplitude 1023 and an upsampling factor of 8. With these values the sum of 32 full-scale sinusoids just fits in 16 bits, which exercises the extreme output range. Each sweep yields exactly eight outputs with a four-cycle gap, so both the interpolation weights and the cadence can be seen at every step. The stimulus patterns cover zero increments (a constant output), distinct per-slot frequencies, and increments close to a full turn that wrap the phase every sample.

// File: rtl/fade_pkg.sv
package fade_pkg;

  // Parabolic half-wave per half turn; sign from the index MSB.
  function automatic int wave_val(input int idx, input int la, input int amp);
    int h;
    int t;
    int mag;
    h   = 1 << (la - 1);
    t   = idx & (h - 1);
    mag = (amp * 4 * t * (h - t)) >> (2 * (la - 1));
    return ((idx >> (la - 1)) & 1) != 0 ? -mag : mag;
  endfunction

endpackage

// File: rtl/fade_phase_bank.sv
module fade_phase_bank #(
  parameter int NSIN = 32,
  parameter int PW   = 16,
  localparam int SW  = $clog2(NSIN)
) (
  input  logic          clk,
  input  logic          ph_we,
  input  logic [SW-1:0] ph_wa,
  input  logic [PW-1:0] ph_wd,
  input  logic          inc_we,
  input  logic [SW-1:0] inc_wa,
  input  logic [PW-1:0] inc_wd,
  input  logic [SW-1:0] rd_a,
  output logic [PW-1:0] rd_ph,
  output logic [PW-1:0] rd_inc
);
  logic [PW-1:0] ph_mem  [NSIN];
  logic [PW-1:0] inc_mem [NSIN];

  always_ff @(posedge clk) begin
    if (ph_we) ph_mem[ph_wa] <= ph_wd;
    if (inc_we) inc_mem[inc_wa] <= inc_wd;
  end

  assign rd_ph  = ph_mem[rd_a];
  assign rd_inc = inc_mem[rd_a];
endmodule

// File: rtl/fade_wave_lut.sv
module fade_wave_lut #(
  parameter int LA  = 8,
  parameter int AMP = 1023,
  parameter int VW  = 12
) (
  input  logic [LA-1:0]        idx,
  output logic signed [VW-1:0] sin_v,
  output logic signed [VW-1:0] cos_v
);
  import fade_pkg::*;
  localparam logic [LA-1:0] QTR = LA'(1 << (LA - 2));
  logic [LA-1:0] cidx;

  always_comb begin
    cidx  = idx + QTR;
    sin_v = VW'(wave_val(int'(idx), LA, AMP));
    cos_v = VW'(wave_val(int'(cidx), LA, AMP));
  end
endmodule

// File: rtl/fade_interp.sv
module fade_interp #(
  parameter int OW  = 16,
  parameter int UPL = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 load,
  input  logic signed [OW-1:0] load_i,
  input  logic signed [OW-1:0] load_q,
  input  logic                 tick,
  input  logic [UPL-1:0]       step,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 out_valid
);
  localparam int DW = OW + UPL + 2;

  logic signed [OW-1:0] y0_i, y1_i, y0_q, y1_q;
  logic [1:0]           fill;
  logic signed [DW-1:0] pr_i, pr_q, sh_i, sh_q, wt;

  always_comb begin
    wt   = DW'($signed({1'b0, step}));
    pr_i = DW'($signed({y1_i[OW-1], y1_i}) - $signed({y0_i[OW-1], y0_i})) * wt;
    pr_q = DW'($signed({y1_q[OW-1], y1_q}) - $signed({y0_q[OW-1], y0_q})) * wt;
    sh_i = pr_i >>> UPL;
    sh_q = pr_q >>> UPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y0_i <= '0; y1_i <= '0; y0_q <= '0; y1_q <= '0;
      fill <= '0; out_i <= '0; out_q <= '0; out_valid <= 1'b0;
    end else if (clr) begin
      fill      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (load) begin
        y0_i <= y1_i;
        y0_q <= y1_q;
        y1_i <= load_i;
        y1_q <= load_q;
        fill <= (fill == 2'd2) ? 2'd2 : fill + 2'd1;
      end else if (tick && fill == 2'd2) begin
        out_i     <= y0_i + OW'(sh_i);
        out_q     <= y0_q + OW'(sh_q);
        out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fade_sos_gen.sv
module fade_sos_gen #(
  parameter int NSIN = 32,
  parameter int PW   = 16,
  parameter int LA   = 8,
  parameter int UPL  = 3,
  parameter int AMP  = 1023,
  parameter int OW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     cfg_we,
  input  logic [$clog2(NSIN)-1:0]  cfg_sel,
  input  logic [PW-1:0]            cfg_phase,
  input  logic [PW-1:0]            cfg_inc,
  output logic signed [OW-1:0]     out_i,
  output logic signed [OW-1:0]     out_q,
  output logic                     out_valid
);
  localparam int SW  = $clog2(NSIN);
  localparam int SPW = SW - UPL;
  localparam int AW  = OW + 2;
  localparam int VW  = $clog2(AMP + 1) + 2;

  logic [SW-1:0]        slot;
  logic                 primed;
  logic [PW-1:0]        rd_ph, rd_inc, nx_ph;
  logic [LA-1:0]        idx   [2];
  logic signed [VW-1:0] sv    [2];
  logic signed [VW-1:0] cv    [2];
  logic signed [AW-1:0] d_i, d_q, dsum_i, dsum_q, acc_i, acc_q, acc_nx_i, acc_nx_q;
  logic                 sweep_end, tick;

  always_comb begin
    nx_ph  = primed ? rd_ph + rd_inc : rd_ph;
    idx[0] = rd_ph[PW-1 -: LA];
    idx[1] = nx_ph[PW-1 -: LA];
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lut
      fade_wave_lut #(.LA(LA), .AMP(AMP), .VW(VW)) u_lut (
        .idx(idx[g]), .sin_v(sv[g]), .cos_v(cv[g])
      );
    end
  endgenerate

  fade_phase_bank #(.NSIN(NSIN), .PW(PW)) u_bank (
    .clk    (clk),
    .ph_we  (run | cfg_we),
    .ph_wa  (run ? slot : cfg_sel),
    .ph_wd  (run ? nx_ph : cfg_phase),
    .inc_we (~run & cfg_we),
    .inc_wa (cfg_sel),
    .inc_wd (cfg_inc),
    .rd_a   (slot),
    .rd_ph  (rd_ph),
    .rd_inc (rd_inc)
  );

  always_comb begin
    d_i       = AW'(cv[1]) - (primed ? AW'(cv[0]) : AW'(0));
    d_q       = AW'(sv[1]) - (primed ? AW'(sv[0]) : AW'(0));
    acc_nx_i  = acc_i + dsum_i + d_i;
    acc_nx_q  = acc_q + dsum_q + d_q;
    sweep_end = run && (slot == SW'(NSIN - 1));
    tick      = run && (slot[SPW-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot   <= '0;
      primed <= 1'b0;
      dsum_i <= '0;
      dsum_q <= '0;
      acc_i  <= '0;
      acc_q  <= '0;
    end else begin
      slot <= sweep_end ? '0 : slot + 1'b1;
      if (sweep_end) begin
        dsum_i <= '0;
        dsum_q <= '0;
        acc_i  <= acc_nx_i;
        acc_q  <= acc_nx_q;
        primed <= 1'b1;
      end else begin
        dsum_i <= dsum_i + d_i;
        dsum_q <= dsum_q + d_q;
      end
    end
  end

  fade_interp #(.OW(OW), .UPL(UPL)) u_interp (
    .clk       (clk),
    .rst       (rst),
    .clr       (~run),
    .load      (sweep_end),
    .load_i    (OW'(acc_nx_i)),
    .load_q    (OW'(acc_nx_q)),
    .tick      (tick),
    .step      (slot[SW-1:SPW]),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/fade_sos_chk.sv
module fade_sos_chk #(
  parameter int OW    = 16,
  parameter int BOUND = 32736
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q,
  input logic                 out_valid
);
  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !out_valid);

  // R7
  valid_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(run));

  // R4
  always_ff @(posedge clk) begin
    if (!rst && out_valid) begin
      amp_bound_chk: assert (int'(out_i) <= BOUND && int'(out_i) >= -BOUND &&
                             int'(out_q) <= BOUND && int'(out_q) >= -BOUND);
    end
  end
endmodule

bind fade_sos_gen fade_sos_chk #(.OW(OW), .BOUND(NSIN * AMP)) u_chk (
  .clk(clk), .rst(rst), .run(run),
  .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
);

// File: tb/fade_sos_gen_test.sv
module fade_sos_gen_test;
  localparam int NSIN = 32;
  localparam int NOUT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_sel = '0;
  logic [15:0] cfg_phase = '0;
  logic [15:0] cfg_inc = '0;
  logic signed [15:0] out_i, out_q;
  logic        out_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int mph  [NSIN];
  int minc [NSIN];

  always #5 clk = ~clk;

  fade_sos_gen uut (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_phase(cfg_phase), .cfg_inc(cfg_inc),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 table, written from the requirement text
  function automatic int tb_wave(input int x);
    int t;
    int m;
    t = x % 128;
    m = (1023 * 4 * t * (128 - t)) / 16384;
    return (x >= 128) ? -m : m;
  endfunction

  function automatic int model_y(input int m, input bit quad);
    int s = 0;
    for (int k = 0; k < NSIN; k++) begin
      int ph;
      int ix;
      ph = (mph[k] + m * minc[k]) & 16'hFFFF;
      ix = ph >> 8;
      if (!quad) ix = (ix + 64) % 256;
      s += tb_wave(ix);
    end
    return s;
  endfunction

  task automatic set_pattern(input int pat);
    for (int k = 0; k < NSIN; k++) begin
      case (pat)
        0: begin mph[k] = k * 2048; minc[k] = 0; end
        1: begin mph[k] = (k * 997) & 16'hFFFF; minc[k] = 37 * k + 5; end
        default: begin mph[k] = (16'hF000 + k * 131) & 16'hFFFF; minc[k] = 16'hFFFF - 300 * k; end
      endcase
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_i == 0, "R1", out_i, 0);
    check(out_q == 0, "R1", out_q, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stream(input int pat, input bit poke);
    int got = 0;
    int cyc = 0;
    int last = 0;
    @(negedge clk);
    run = 1'b0;
    set_pattern(pat);
    for (int k = 0; k < NSIN; k++) begin
      cfg_sel = 5'(k); cfg_phase = 16'(mph[k]); cfg_inc = 16'(minc[k]); cfg_we = 1'b1;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    while (got < NOUT && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (poke && (cyc == 100 || cyc == 141)) begin
        cfg_we = 1'b1; cfg_sel = 5'd3; cfg_phase = 16'h1234; cfg_inc = 16'h0777;
      end else begin
        cfg_we = 1'b0;
      end
      if (out_valid) begin
        int p;
        int j;
        int ei;
        int eq;
        string tg;
        p  = got / 8 + 1;
        j  = got % 8;
        ei = model_y(p - 1, 0) + (((model_y(p, 0) - model_y(p - 1, 0)) * j) >>> 3);
        eq = model_y(p - 1, 1) + (((model_y(p, 1) - model_y(p - 1, 1)) * j) >>> 3);
        if (poke) tg = "R8";
        else if (pat == 0) tg = "R2";
        else if (got == 0) tg = "R3";
        else if (j == 0) tg = "R4";
        else tg = "R5";
        check(int'(out_i) == ei, tg, out_i, ei);
        check(int'(out_q) == eq, tg, out_q, eq);
        // R6 latency and cadence
        if (got == 0) check(cyc == 2 * NSIN + 1, "R6", cyc, 2 * NSIN + 1);
        else check(cyc - last == 4, "R6", cyc - last, 4);
        last = cyc;
        got++;
      end
    end
    cfg_we = 1'b0;
    check(got == NOUT, "R6", got, NOUT);
    run = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      // R7
      check(out_valid == 1'b0, "R7", out_valid, 0);
    end
  endtask

  initial begin
    t_reset();
    t_stream(0, 1'b0);
    t_stream(1, 1'b0);
    t_stream(2, 1'b0);
    t_stream(1, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule